// File: doc/BRIEF.md
# Buffered SPI Slave

This block is an SPI slave for the serial side of a chip. It has a simple register-style port toward a local host. The host places one outgoing byte at a time into a transmit holding register and takes incoming bytes from a receive holding register. Three sticky status flags report the following events:

- a finished byte;
- a host write that found the transmit holding register still occupied;
- a byte that arrived while the previous one was still unread.

The flags are masked and merged into a single interrupt line.

The serial clock, select and data input are brought into the system clock through two-flop synchronizers, and their edges are found there. For this reason the system clock must run at least four times faster than SCK. Transfers use SPI mode 0 with the MSB first: MOSI is captured on the rising SCK edge, and MISO moves on the falling edge. A mode input chooses between two ways of framing bytes. In 4-wire operation the active-low select gates the slave and re-frames bytes. In 3-wire operation the select is ignored, and only the enable input can re-frame bytes.

Top module: `spi_slave_buf`

## Requirements
- R1: After the 8th rising SCK edge seen while active, the assembled byte (first bit received in bit 7) appears on `rx_data`, `rx_unread` goes to 1, and status bit 0 (done) is set.
- R2: A host write that finds the transmit holding register empty is accepted. If the shift register is empty, the byte moves into it at once, and its bit 7 appears on `miso` before any SCK edge.
- R3: A byte accepted while the shift register is busy moves into the shift register when the current byte ends, and it is shifted out in the next byte.
- R4: A host write while the holding register is still occupied sets status bit 1 (collision) and is discarded. The bytes sent afterwards are the previously held ones.
- R5: A byte that completes while `rx_unread` is 1 (and no read happens in that cycle) sets status bit 2 (overrun) and is dropped. `rx_data` keeps the older byte.
- R6: With `three_wire`=0 the slave is active only while `en`=1 and `ss_n`=0. `miso_oe` follows this. SCK edges while inactive are ignored, and a falling edge of `ss_n` restarts byte framing.
- R7: With `three_wire`=1, `ss_n` is ignored. Framing restarts only when `en` goes to 0 and back to 1.
- R8: Each status bit stays set until the host pulses the matching `flag_clr` bit. A new event in the same cycle wins over the clear.
- R9: `irq` is 1 exactly when some status bit is 1 and its bit in `irq_mask` is 1.
- R10: A `rd_en` pulse clears `rx_unread`. A read in the same cycle as a byte completion counts as done before the completion.
- R11: Bytes leave on `miso` MSB first. Each falling SCK edge within a byte advances one bit, and bits shifted in behind the data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Slave enable; a low level clears the bit count |
| three_wire | input | 1 | 1: select ignored; 0: select used |
| irq_mask | input | 3 | Per-flag interrupt enables |
| wr_en | input | 1 | Host write strobe for the transmit byte |
| wr_data | input | 8 | Host transmit byte |
| rd_en | input | 1 | Host read strobe; marks the receive byte as read |
| flag_clr | input | 3 | Per-flag clear pulses |
| rx_data | output | 8 | Receive holding register |
| flags | output | 3 | Status: bit 0 done, bit 1 collision, bit 2 overrun |
| rx_unread | output | 1 | Receive holding register holds an unread byte |
| irq | output | 1 | Masked OR of the status flags |
| sck | input | 1 | Serial clock from the master |
| mosi | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low select |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso` |

## Verification
The assertions check the following on every cycle:

- status bits never drop without a clear;
- a finished byte always raises the done flag;
- a refused write both flags the collision and leaves the holding byte intact;
- an unread receive byte stays frozen;
- a read marks the buffer empty;
- the output is released whenever the slave is disabled.

The bench scenarios cover the behaviour that needs whole transfers:

- MSB-first ordering on both lines;
- the handover of the held transmit byte at a byte boundary;
- re-framing by a select edge in one mode and by an enable toggle in the other;
- select being ignored in 3-wire operation.

// File: rtl/spi_slave_buf.sv
module spi_slave_buf #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         three_wire,
  input  logic [2:0]   irq_mask,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic [2:0]   flag_clr,
  output logic [W-1:0] rx_data,
  output logic [2:0]   flags,
  output logic         rx_unread,
  output logic         irq,
  input  logic         sck,
  input  logic         mosi,
  input  logic         ss_n,
  output logic         miso,
  output logic         miso_oe
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic [2:0]    sck_q, ss_q;
  logic [1:0]    mosi_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  rx_sh, tx_buf, sh_tx;
  logic          tx_full, sh_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q  <= '0;
      ss_q   <= '1;
      mosi_q <= '0;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      ss_q   <= {ss_q[1:0], ss_n};
      mosi_q <= {mosi_q[0], mosi};
    end

  wire sck_rise  = sck_q[1] & ~sck_q[2];
  wire sck_fall  = ~sck_q[1] & sck_q[2];
  wire ss_fall   = ~ss_q[1] & ss_q[2];
  wire active    = en & (three_wire | ~ss_q[1]);
  wire sample    = active & sck_rise;
  wire byte_done = sample & (cnt == CW'(W - 1));
  wire keep_old  = rx_unread & ~rd_en;
  wire [W-1:0] rx_next = {rx_sh[W-2:0], mosi_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                        cnt <= '0;
    else if (!en || (!three_wire && ss_fall)) cnt <= '0;
    else if (byte_done)                cnt <= '0;
    else if (sample)                   cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sh <= '0;
    else if (sample) rx_sh <= rx_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data   <= '0;
      rx_unread <= 1'b0;
    end else if (byte_done && !keep_old) begin
      rx_data   <= rx_next;
      rx_unread <= 1'b1;
    end else if (rd_en) begin
      rx_unread <= 1'b0;
    end

  wire [2:0] flag_set = {byte_done & keep_old, wr_en & tx_full, byte_done};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | flag_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
      sh_tx   <= '0;
      sh_full <= 1'b0;
    end else begin
      if (wr_en && !tx_full) begin
        tx_buf  <= wr_data;
        tx_full <= 1'b1;
      end
      if (byte_done) begin
        if (tx_full) begin
          sh_tx   <= tx_buf;
          sh_full <= 1'b1;
          tx_full <= 1'b0;
        end else begin
          sh_tx   <= '0;
          sh_full <= 1'b0;
        end
      end else if (tx_full && !sh_full) begin
        sh_tx   <= tx_buf;
        sh_full <= 1'b1;
        tx_full <= 1'b0;
      end else if (active && sck_fall && cnt != '0) begin
        sh_tx <= {sh_tx[W-2:0], 1'b0};
      end
    end

  assign irq     = |(flags & irq_mask);
  assign miso    = sh_tx[W-1];
  assign miso_oe = active;
endmodule

// File: rtl/spi_slave_buf_chk.sv
module spi_slave_buf_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         wr_en,
  input logic         rd_en,
  input logic [2:0]   flag_clr,
  input logic [2:0]   flags,
  input logic [2:0]   irq_mask,
  input logic         irq,
  input logic [W-1:0] rx_data,
  input logic         rx_unread,
  input logic         miso_oe,
  input logic         tx_full,
  input logic [W-1:0] tx_buf,
  input logic         byte_done
);
  a_r1_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> flags[0]);

  a_r4_collision: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && tx_full |=> flags[1] && $stable(tx_buf));

  a_r5_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    rx_unread && !rd_en |=> $stable(rx_data));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !byte_done |=> !rx_unread);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == 3'b000));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !miso_oe);

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & irq_mask) == 3'b000 |-> !irq);
endmodule

bind spi_slave_buf spi_slave_buf_chk #(.W(W)) u_chk (.*);

// File: tb/spi_slave_buf_tb.sv
`timescale 1ns/1ps
module spi_slave_buf_tb;
  logic clk = 0, rst_n = 0, en = 1, three_wire = 0;
  logic [2:0] irq_mask = 3'b111, flag_clr = 0;
  logic wr_en = 0, rd_en = 0, sck = 0, mosi = 0, ss_n = 1;
  logic [7:0] wr_data = 0;
  logic [7:0] rx_data;
  logic [2:0] flags;
  logic rx_unread, irq, miso, miso_oe;

  spi_slave_buf u_dut (.*);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit settled = 0, done = 0;

  logic [7:0] m_rx = 0, m_rxsh = 0, m_txbuf = 0, m_sh = 0;
  logic [2:0] m_flags = 0;
  bit m_unread = 0, m_txfull = 0, m_shfull = 0;
  int m_cnt = 0;

  function automatic bit m_active();
    return en && (three_wire || !ss_n);
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (settled && rst_n) begin
    check(rx_data == m_rx, "R1 rx_data", rx_data, m_rx);
    check(flags == m_flags, "R8 flags", {5'b0, flags}, {5'b0, m_flags});
    check(rx_unread == m_unread, "R10 rx_unread", {7'b0, rx_unread}, {7'b0, m_unread});
    check(irq == |(m_flags & irq_mask), "R9 irq", {7'b0, irq}, {7'b0, |(m_flags & irq_mask)});
    check(miso_oe == m_active(), "R6 miso_oe", {7'b0, miso_oe}, {7'b0, m_active()});
    if (m_active()) check(miso == m_sh[7], "R11 miso", {7'b0, miso}, {7'b0, m_sh[7]});
  end

  task automatic settle();
    repeat (6) @(posedge clk);
    settled = 1;
    repeat (2) @(posedge clk);
  endtask

  task automatic host_write(input logic [7:0] b);
    @(negedge clk); settled = 0; wr_en = 1; wr_data = b;
    @(negedge clk); wr_en = 0;
    if (m_txfull) m_flags[1] = 1;
    else begin m_txbuf = b; m_txfull = 1; end
    if (m_txfull && !m_shfull) begin m_sh = m_txbuf; m_shfull = 1; m_txfull = 0; end
    settle();
  endtask

  task automatic host_read(output logic [7:0] b);
    @(negedge clk); settled = 0; b = rx_data; rd_en = 1;
    @(negedge clk); rd_en = 0; m_unread = 0;
    settle();
  endtask

  task automatic host_clr(input logic [2:0] c);
    @(negedge clk); settled = 0; flag_clr = c;
    @(negedge clk); flag_clr = 0; m_flags = m_flags & ~c;
    settle();
  endtask

  task automatic set_ss(input logic v);
    @(negedge clk); settled = 0;
    if (!three_wire && ss_n && !v) m_cnt = 0;
    ss_n = v;
    settle();
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); settled = 0; en = v;
    if (!v) m_cnt = 0;
    settle();
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk); settled = 0; three_wire = v;
    settle();
  endtask

  task automatic sck_bit(input logic b, output logic seen);
    @(negedge clk); mosi = b; seen = miso;
    repeat (3) @(posedge clk);
    @(negedge clk); settled = 0; sck = 1;
    if (m_active()) begin
      m_rxsh = {m_rxsh[6:0], b};
      m_cnt++;
      if (m_cnt == 8) begin
        m_cnt = 0;
        m_flags[0] = 1;
        if (m_unread) m_flags[2] = 1;
        else begin m_rx = m_rxsh; m_unread = 1; end
        if (m_txfull) begin m_sh = m_txbuf; m_txfull = 0; end
        else begin m_sh = 0; m_shfull = 0; end
      end
    end
    settle();
    @(negedge clk); settled = 0; sck = 0;
    if (m_active() && m_cnt != 0) m_sh = {m_sh[6:0], 1'b0};
    settle();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] got);
    got = 0;
    for (int i = n - 1; i >= 0; i--) begin
      logic s;
      sck_bit(b[i], s);
      got = {got[6:0], s};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, rd;
    repeat (4) @(posedge clk);
    rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(flags == 0 && irq == 0 && rx_unread == 0 && miso_oe == 0 && rx_data == 0,
          "R8 reset state", {flags, irq, rx_unread, miso_oe, 2'b0}, 8'h00);
    settled = 1;

    host_write(8'hA5);
    check(miso == 1'b1, "R2 first bit after write", {7'b0, miso}, 8'h01);
    host_write(8'h3C);
    host_write(8'h77);
    check(flags[1] == 1'b1, "R4 collision flag", {5'b0, flags}, 8'h02);
    set_ss(0);
    send_bits(8'h96, 8, got);
    check(got == 8'hA5, "R11 MSB-first out", got, 8'hA5);
    check(rx_data == 8'h96, "R1 received byte", rx_data, 8'h96);
    check(flags == 3'b011, "R1 done flag", {5'b0, flags}, 8'h03);
    host_clr(3'b111);
    check(irq == 0, "R9 irq after clear", {7'b0, irq}, 8'h00);

    send_bits(8'h5A, 8, got);
    check(got == 8'h3C, "R3 R4 held byte sent", got, 8'h3C);
    check(rx_data == 8'h96 && flags[2], "R5 overrun keeps old", rx_data, 8'h96);
    host_read(rd);
    check(rd == 8'h96 && rx_unread == 0, "R10 read", rd, 8'h96);
    host_clr(3'b111);

    send_bits(8'hE0, 3, got);
    set_ss(1);
    set_ss(0);
    send_bits(8'hC3, 8, got);
    check(rx_data == 8'hC3, "R6 select edge reframes", rx_data, 8'hC3);
    check(got == 8'h00, "R11 zero fill", got, 8'h00);
    host_read(rd);
    host_clr(3'b111);
    set_ss(1);
    send_bits(8'hFF, 8, got);
    check(flags == 0 && miso_oe == 0, "R6 ignored while deselected", {5'b0, flags}, 8'h00);

    set_mode(1);
    send_bits(8'h05, 3, got);
    set_ss(0);
    set_ss(1);
    send_bits(8'h13, 5, got);
    check(rx_data == 8'hB3, "R7 select ignored", rx_data, 8'hB3);
    host_read(rd);
    send_bits(8'h03, 2, got);
    set_en(0);
    set_en(1);
    send_bits(8'h4E, 8, got);
    check(rx_data == 8'h4E, "R7 enable toggle reframes", rx_data, 8'h4E);

    host_clr(3'b111);
    @(negedge clk); irq_mask = 3'b100;
    send_bits(8'h11, 8, got);
    check(flags == 3'b101 && irq == 1, "R9 masked overrun", {5'b0, flags}, 8'h05);
    host_clr(3'b100);
    check(irq == 0 && flags == 3'b001, "R9 done masked off", {5'b0, flags}, 8'h01);

    done = 1;
    settled = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule